// File: doc/BRIEF.md
# Low-Power DDR2 Power-Up Sequencer

This block brings a low-power DDR2 memory device from power-on to normal operation. A start pulse launches the sequence. The block then presents a fixed series of commands, one at a time, on a command port with a valid/ready handshake. First come two idle (NOP) commands. Next is a device reset, sent as a mode-register write to register 63. Then come a ZQ calibration, sent as a mode-register write to register 10, and mode-register writes to registers 1, 2, 3 and 16. The series ends with a normal-mode command.

Three programmable cycle-count waits separate the early steps: a short gap, a long power-up pause and the post-reset settling time. A side output tells the memory controller which ZQ calibration type to apply. After the normal-mode command, the block pulses a strobe that loads the refresh-timer count, then raises done and keeps it high until reset. Mode-register data contents are outside this block, and so are the physical layer and routine refresh scheduling.

Top module: `lpddr2_init_seq`

## Requirements
- R1: After a synchronous reset, cmd_valid, rtr_load and done are 0 and zq_type is 00. The zq_type encoding is 00 none, 01 init/reset calibration, 10 long, 11 short.
- R2: A start pulse seen while idle makes cmd_valid high in the next cycle, carrying a NOP (cmd_op 00).
- R3: The commands are presented in this order: NOP, NOP, MRW 63, MRW 10, MRW 1, MRW 2, MRW 3, MRW 16, NORMAL. The cmd_op encoding is 00 NOP, 01 mode-register write, 10 normal mode. cmd_mr_addr carries the 6-bit register number for mode-register writes.
- R4: While cmd_valid is high and cmd_ready is low, cmd_valid, cmd_op and cmd_mr_addr hold their values. A command counts as accepted only in a cycle where both are high, and the next command never appears before that.
- R5: After the first NOP is accepted, cmd_valid stays low for exactly GAP_CYC cycles. After the second NOP it stays low for PWRUP_CYC cycles, and after MRW 63 for INIT5_CYC cycles. Every later command is presented in the cycle right after the previous one is accepted.
- R6: zq_type is 01 from the cycle after start until MRW 10 is accepted, and 11 from the next cycle on. It is never 10.
- R7: rtr_load is high for exactly one cycle, the cycle after the normal-mode command is accepted.
- R8: done rises the cycle after rtr_load and stays high until reset. No command is presented while done is high.
- R9: start has no effect while a sequence is running or after done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launches the sequence when idle |
| cmd_valid | output | 1 | A command is presented |
| cmd_ready | input | 1 | Controller accepts the presented command |
| cmd_op | output | 2 | Command type: 00 NOP, 01 mode-register write, 10 normal |
| cmd_mr_addr | output | 6 | Mode-register number for mode-register writes |
| zq_type | output | 2 | ZQ calibration type: 00 none, 01 init, 10 long, 11 short |
| rtr_load | output | 1 | One-cycle strobe to load the refresh-timer count |
| done | output | 1 | Sequence complete, sticky until reset |

## Verification
The bench builds the block with GAP_CYC=3, PWRUP_CYC=7 and INIT5_CYC=5. These are three distinct small values, so an exact count of the low-valid gap after each accepted command shows whether each wait is tied to the right step. The short values also leave room in the cycle budget for ready stalls of varying length on every command, for start held high through the whole run, and for a reset in the middle of the sequence followed by a relaunch.

// File: rtl/lpddr2_init_pkg.sv
package lpddr2_init_pkg;

  typedef enum logic [1:0] {
    OP_NOP    = 2'b00,
    OP_MRW    = 2'b01,
    OP_NORMAL = 2'b10
  } cmd_op_e;

  typedef enum logic [1:0] {
    WAIT_NONE  = 2'b00,
    WAIT_GAP   = 2'b01,
    WAIT_PWRUP = 2'b10,
    WAIT_INIT5 = 2'b11
  } wait_sel_e;

  localparam logic [1:0] ZQ_NONE  = 2'b00;
  localparam logic [1:0] ZQ_INIT  = 2'b01;
  localparam logic [1:0] ZQ_LONG  = 2'b10;
  localparam logic [1:0] ZQ_SHORT = 2'b11;

  localparam int unsigned N_STEPS = 9;
  localparam int unsigned STEP_W  = $clog2(N_STEPS + 1);

endpackage

// File: rtl/init_step_rom.sv
module init_step_rom
  import lpddr2_init_pkg::*;
(
  input  logic [STEP_W-1:0] step,
  output cmd_op_e           op,
  output logic [5:0]        mr_addr,
  output wait_sel_e         wait_sel,
  output logic              is_zq,
  output logic              is_last
);

  always_comb begin
    op       = OP_NOP;
    mr_addr  = 6'd0;
    wait_sel = WAIT_NONE;
    is_zq    = 1'b0;
    is_last  = 1'b0;
    case (step)
      4'd0: wait_sel = WAIT_GAP;
      4'd1: wait_sel = WAIT_PWRUP;
      4'd2: begin op = OP_MRW; mr_addr = 6'd63; wait_sel = WAIT_INIT5; end
      4'd3: begin op = OP_MRW; mr_addr = 6'd10; is_zq = 1'b1; end
      4'd4: begin op = OP_MRW; mr_addr = 6'd1; end
      4'd5: begin op = OP_MRW; mr_addr = 6'd2; end
      4'd6: begin op = OP_MRW; mr_addr = 6'd3; end
      4'd7: begin op = OP_MRW; mr_addr = 6'd16; end
      4'd8: begin op = OP_NORMAL; is_last = 1'b1; end
      default: ;
    endcase
  end

endmodule

// File: rtl/init_gap_timer.sv
module init_gap_timer #(
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          expired
);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)
      cnt <= '0;
    else if (load)
      cnt <= load_val;
    else if (cnt != '0)
      cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);

endmodule

// File: rtl/lpddr2_init_seq.sv
module lpddr2_init_seq
  import lpddr2_init_pkg::*;
#(
  parameter int unsigned GAP_CYC   = 20,
  parameter int unsigned PWRUP_CYC = 40000,
  parameter int unsigned INIT5_CYC = 2000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  output logic       cmd_valid,
  input  logic       cmd_ready,
  output logic [1:0] cmd_op,
  output logic [5:0] cmd_mr_addr,
  output logic [1:0] zq_type,
  output logic       rtr_load,
  output logic       done
);

  localparam int unsigned MAX_AB = (GAP_CYC > PWRUP_CYC) ? GAP_CYC : PWRUP_CYC;
  localparam int unsigned MAX_W  = (MAX_AB > INIT5_CYC) ? MAX_AB : INIT5_CYC;
  localparam int unsigned CW     = (MAX_W < 2) ? 1 : $clog2(MAX_W + 1);

  typedef enum logic [2:0] {S_IDLE, S_ISSUE, S_WAIT, S_LOAD, S_DONE} state_e;

  state_e            state;
  logic [STEP_W-1:0] step;
  logic [CW-1:0]     cur_wait;
  logic              cur_zq;
  logic              cur_last;
  logic              tmr_load;
  logic [CW-1:0]     tmr_val;
  logic              tmr_expired;
  logic              accept;
  logic              launch;

  cmd_op_e   rom_op;
  logic [5:0] rom_addr;
  wait_sel_e rom_wait;
  logic      rom_zq;
  logic      rom_last;
  logic [CW-1:0] rom_wait_cyc;

  init_step_rom u_rom (
    .step     (step),
    .op       (rom_op),
    .mr_addr  (rom_addr),
    .wait_sel (rom_wait),
    .is_zq    (rom_zq),
    .is_last  (rom_last)
  );

  always_comb begin
    case (rom_wait)
      WAIT_GAP:   rom_wait_cyc = CW'(GAP_CYC);
      WAIT_PWRUP: rom_wait_cyc = CW'(PWRUP_CYC);
      WAIT_INIT5: rom_wait_cyc = CW'(INIT5_CYC);
      default:    rom_wait_cyc = '0;
    endcase
  end

  assign accept   = (state == S_ISSUE) && cmd_valid && cmd_ready;
  assign tmr_load = accept && !cur_last && (cur_wait != '0);
  assign tmr_val  = cur_wait - 1'b1;
  assign launch   = ((state == S_IDLE) && start) ||
                    (accept && !cur_last && (cur_wait == '0)) ||
                    ((state == S_WAIT) && tmr_expired);

  init_gap_timer #(.CW(CW)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_expired)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= S_IDLE;
      step        <= '0;
      cmd_valid   <= 1'b0;
      cmd_op      <= OP_NOP;
      cmd_mr_addr <= '0;
      cur_wait    <= '0;
      cur_zq      <= 1'b0;
      cur_last    <= 1'b0;
      zq_type     <= ZQ_NONE;
      rtr_load    <= 1'b0;
      done        <= 1'b0;
    end else begin
      if (launch) begin
        state       <= S_ISSUE;
        cmd_valid   <= 1'b1;
        cmd_op      <= rom_op;
        cmd_mr_addr <= rom_addr;
        cur_wait    <= rom_wait_cyc;
        cur_zq      <= rom_zq;
        cur_last    <= rom_last;
        step        <= step + 1'b1;
      end
      if ((state == S_IDLE) && start)
        zq_type <= ZQ_INIT;
      if (accept && cur_zq)
        zq_type <= ZQ_SHORT;
      if (accept && cur_last) begin
        state     <= S_LOAD;
        cmd_valid <= 1'b0;
        rtr_load  <= 1'b1;
      end else if (accept && (cur_wait != '0)) begin
        state     <= S_WAIT;
        cmd_valid <= 1'b0;
      end
      if (state == S_LOAD) begin
        rtr_load <= 1'b0;
        done     <= 1'b1;
        state    <= S_DONE;
      end
    end
  end

  // R4
  hold_until_ready_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_op) && $stable(cmd_mr_addr)));

  // R6
  zq_during_cal_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op == OP_MRW && cmd_mr_addr == 6'd10) |-> (zq_type == ZQ_INIT));

  // R6
  zq_never_long_chk: assert property (@(posedge clk) disable iff (rst)
    zq_type != ZQ_LONG);

  // R7
  rtr_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rtr_load |=> (!rtr_load && done));

  // R8
  done_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> done);

  // R8
  quiet_when_done_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !cmd_valid);

endmodule

// File: tb/test_lpddr2_init_seq.sv
`timescale 1ns/1ps
module test_lpddr2_init_seq;

  localparam int unsigned GAP   = 3;
  localparam int unsigned PWRUP = 7;
  localparam int unsigned INIT5 = 5;

  logic       clk = 1'b0;
  logic       rst;
  logic       start;
  logic       cmd_valid;
  logic       cmd_ready;
  logic [1:0] cmd_op;
  logic [5:0] cmd_mr_addr;
  logic [1:0] zq_type;
  logic       rtr_load;
  logic       done;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  lpddr2_init_seq #(.GAP_CYC(GAP), .PWRUP_CYC(PWRUP), .INIT5_CYC(INIT5)) i_lpddr2_init_seq (
    .clk(clk), .rst(rst), .start(start), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_mr_addr(cmd_mr_addr), .zq_type(zq_type),
    .rtr_load(rtr_load), .done(done)
  );

  // entry: {op[1:0], addr[5:0], gap before this command[7:0]}
  localparam logic [15:0] SEQ [9] = '{
    {2'b00, 6'd0,  8'd0},
    {2'b00, 6'd0,  8'(GAP)},
    {2'b01, 6'd63, 8'(PWRUP)},
    {2'b01, 6'd10, 8'(INIT5)},
    {2'b01, 6'd1,  8'd0},
    {2'b01, 6'd2,  8'd0},
    {2'b01, 6'd3,  8'd0},
    {2'b01, 6'd16, 8'd0},
    {2'b10, 6'd0,  8'd0}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected completion");
      summary();
    end
  end

  initial begin
    int gap;
    rst = 1'b1; start = 1'b0; cmd_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(cmd_valid == 0, "R1 valid", cmd_valid, 0);
    chk(done == 0 && rtr_load == 0, "R1 done/rtr", {done, rtr_load}, 0);
    chk(zq_type == 2'b00, "R1 zq", zq_type, 0);

    // R2 launch; R9: start held high for the whole run
    start = 1'b1;
    @(negedge clk);
    chk(cmd_valid == 1 && cmd_op == 2'b00, "R2 first NOP", {cmd_valid, cmd_op}, 4);
    chk(zq_type == 2'b01, "R6 zq init after start", zq_type, 1);

    for (int i = 0; i < 9; i++) begin
      gap = 0;
      while (!cmd_valid) begin
        gap++;
        @(negedge clk);
      end
      chk(gap == int'(SEQ[i][7:0]), $sformatf("R5 gap before step %0d", i), gap, int'(SEQ[i][7:0]));
      chk(cmd_op == SEQ[i][15:14], $sformatf("R3 op step %0d", i), cmd_op, SEQ[i][15:14]);
      if (SEQ[i][15:14] == 2'b01)
        chk(cmd_mr_addr == SEQ[i][13:8], $sformatf("R3 addr step %0d", i), cmd_mr_addr, SEQ[i][13:8]);
      chk(zq_type == ((i <= 3) ? 2'b01 : 2'b11), $sformatf("R6 zq step %0d", i), zq_type, (i <= 3) ? 1 : 3);
      for (int s = 0; s < i % 3 + 1; s++) begin
        @(negedge clk);
        chk(cmd_valid == 1 && cmd_op == SEQ[i][15:14], $sformatf("R4 hold step %0d", i),
            {cmd_valid, cmd_op}, {1'b1, SEQ[i][15:14]});
      end
      cmd_ready = 1'b1;
      @(negedge clk);
      cmd_ready = 1'b0;
      if (i == 3)
        chk(zq_type == 2'b11, "R6 zq short after cal", zq_type, 3);
    end

    // R7 / R8
    chk(rtr_load == 1 && done == 0, "R7 rtr pulse", {rtr_load, done}, 2);
    chk(cmd_valid == 0, "R8 no cmd after normal", cmd_valid, 0);
    @(negedge clk);
    chk(rtr_load == 0 && done == 1, "R8 done rise", {rtr_load, done}, 1);
    cmd_ready = 1'b1;
    repeat (10) begin
      @(negedge clk);
      chk(done == 1 && cmd_valid == 0 && rtr_load == 0, "R9 start ignored after done",
          {done, cmd_valid, rtr_load}, 4);
    end
    start = 1'b0;

    // mid-sequence reset then relaunch
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(done == 0 && cmd_valid == 0 && zq_type == 0, "R1 reset after done", {done, cmd_valid, zq_type}, 0);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(cmd_valid == 1 && cmd_op == 2'b00, "R2 relaunch NOP", {cmd_valid, cmd_op}, 4);
    @(negedge clk);
    chk(cmd_valid == 0, "R5 gap after relaunch NOP", cmd_valid, 0);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(cmd_valid == 0 && zq_type == 0 && rtr_load == 0, "R1 reset mid-run", {cmd_valid, zq_type}, 0);
    repeat (PWRUP + 2) @(negedge clk);
    chk(cmd_valid == 0 && done == 0, "R2 idle without start", {cmd_valid, done}, 0);
    summary();
  end

endmodule